// File: doc/BRIEF.md
# I2C Serial Memory Slave Front-End

This block places a byte-wide memory on an I2C bus as a slave. It samples the SDA and SCL lines into the system clock domain and detects Start and Stop conditions. The first byte after a Start is a control byte: it holds a fixed four-bit device-type code, three select bits that must equal the strapped select inputs, and an operation bit. The slave acknowledges the control byte only on a full match. On any mismatch it stays silent until the next Start.

After a write control byte, the master sends a 16-bit word pointer, high byte first. Every byte after that is stored in the internal array at the pointer, and the pointer then steps by one. After a read control byte, the slave shifts out the byte at the pointer, most significant bit first, and steps the pointer. It keeps sending bytes while the master acknowledges, and it lets go of the bus when the master does not.

A repeated Start keeps the pointer. A random read is therefore made of an address-only write followed by a repeated Start and a read. SDA is driven open-drain through an output enable that pulls the line low.

Top module: `i2c_mem_slave`

## Requirements
- R1: A Start (SDA falling while SCL is high) restarts control-byte decoding from any state, including in the middle of a transfer. A Stop (SDA rising while SCL is high) returns the slave to idle with SDA released, and bytes clocked after a Stop get no acknowledge until the next Start.
- R2: The slave acknowledges a control byte, by pulling SDA low during the ninth clock, only when bits 7:4 equal DEV_CODE (default 4'b1010) and bits 3:1 equal sel_i.
- R3: When bits 3:1 of the control byte differ from sel_i, the slave gives no acknowledge to that byte or to any later byte, and it changes no array content until the next Start.
- R4: After a write control byte (bit 0 = 0), the next two bytes load the 16-bit pointer: the first byte into bits 15:8 and the second into bits 7:0. Each of these bytes is acknowledged.
- R5: Each further byte of a write is acknowledged and stored at the pointer, and the pointer then increments by one.
- R6: After a read control byte (bit 0 = 1), the slave sends the byte at the pointer, MSB first, and increments the pointer. It sends the next byte while the master acknowledges. After a master no-acknowledge it releases SDA and waits for a Stop.
- R7: The pointer survives a repeated Start. A read issued with no address phase starts at the current pointer.
- R8: The pointer wraps from 0xFFFF to 0x0000 on both writes and reads, and it never moves into another device's range.
- R9: During reset SDA is released, and the slave comes out of reset idle.
- R10: The array holds 2**MEM_AW bytes, addressed by the low MEM_AW bits of the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pulls SDA low when 1 (open-drain drive) |
| sel_i | input | 3 | Strapped select code compared with control-byte bits 3:1 |

## Verification
The bench builds the slave with MEM_AW = 8, DEV_CODE at its default and sel_i strapped to 3'b101. The 256-byte array means that two pointers differing only above bit 7 reach the same byte. This makes the aliasing rule visible, and it lets the 0xFFFF-to-0x0000 wrap be checked by reading back through the low pointer. The bench drives the bus as a wired-AND of the master and the slave. It can therefore check acknowledge and data bits at the line itself, across random, sequential and current-pointer reads.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WRITE,
    ST_READ
  } slv_state_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PTR_W   = 2 * BYTE_W;
  localparam int unsigned SLOT_W  = 4;   // counts 0..9 clocks of a byte slot
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[SYNC_STAGES-1];
  assign sda_s      = sda_pipe[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  AST_WADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !$isunknown(addr_i)) else $error("write to unknown address"); // R10
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [3:0]  DEV_CODE    = 4'b1010,
  parameter int unsigned MEM_AW      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] sel_i
);
  localparam logic [SLOT_W-1:0] ACK_CLK  = SLOT_W'(BYTE_W);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(BYTE_W + 1);

  logic sda_s, scl_rise, scl_fall, start_w, stop_w;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  slv_state_e              state_q;
  logic [SLOT_W-1:0]       bit_cnt_q;
  logic [BYTE_W-1:0]       rx_q, tx_q, mem_rdata;
  logic [PTR_W-1:0]        ptr_q;
  logic                    sda_oe_q, drv_ack_q, mack_q;
  logic                    active, byte_end, slot_end, ctrl_match, mem_we;

  always_comb begin
    active     = (state_q != ST_IDLE) && !start_w && !stop_w;
    byte_end   = active && scl_fall && (bit_cnt_q == ACK_CLK);
    slot_end   = active && scl_fall && (bit_cnt_q == SLOT_END);
    ctrl_match = (rx_q[7:4] == DEV_CODE) && (rx_q[3:1] == sel_i);
    mem_we     = byte_end && (state_q == ST_WRITE);
  end

  i2c_mem_array #(.AW(MEM_AW), .DW(BYTE_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .addr_i (ptr_q[MEM_AW-1:0]),
    .wdata_i(rx_q),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      sda_oe_q  <= 1'b0;
      drv_ack_q <= 1'b0;
      mack_q    <= 1'b0;
    end else if (start_w) begin
      state_q   <= ST_CTRL;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
      drv_ack_q <= 1'b0;
    end else if (stop_w) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sda_oe_q  <= 1'b0;
      drv_ack_q <= 1'b0;
    end else if (active) begin
      if (scl_rise && bit_cnt_q != SLOT_END) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q < ACK_CLK) rx_q   <= {rx_q[BYTE_W-2:0], sda_s};
        else                     mack_q <= ~sda_s;  // ninth clock: master ack
      end
      if (byte_end) begin
        unique case (state_q)
          ST_CTRL: begin
            if (ctrl_match) begin
              drv_ack_q <= 1'b1;
              sda_oe_q  <= 1'b1;
              state_q   <= rx_q[0] ? ST_READ : ST_ADDR_HI;
            end else begin
              state_q   <= ST_IDLE;
            end
          end
          ST_ADDR_HI: begin
            ptr_q[PTR_W-1:BYTE_W] <= rx_q;
            drv_ack_q <= 1'b1;
            sda_oe_q  <= 1'b1;
            state_q   <= ST_ADDR_LO;
          end
          ST_ADDR_LO: begin
            ptr_q[BYTE_W-1:0] <= rx_q;
            drv_ack_q <= 1'b1;
            sda_oe_q  <= 1'b1;
            state_q   <= ST_WRITE;
          end
          ST_WRITE: begin
            ptr_q     <= ptr_q + 1'b1;
            drv_ack_q <= 1'b1;
            sda_oe_q  <= 1'b1;
          end
          ST_READ:  sda_oe_q <= 1'b0;  // free the line for the master ack
          default:  state_q  <= ST_IDLE;
        endcase
      end else if (slot_end) begin
        bit_cnt_q <= '0;
        drv_ack_q <= 1'b0;
        if (state_q == ST_READ && (drv_ack_q || mack_q)) begin
          tx_q     <= mem_rdata;
          sda_oe_q <= ~mem_rdata[BYTE_W-1];
          ptr_q    <= ptr_q + 1'b1;
        end else begin
          sda_oe_q <= 1'b0;
          if (state_q == ST_READ) state_q <= ST_IDLE;
        end
      end else if (scl_fall && state_q == ST_READ && !drv_ack_q
                   && bit_cnt_q != '0 && bit_cnt_q < ACK_CLK) begin
        sda_oe_q <= ~tx_q[~bit_cnt_q[2:0]];
      end
    end
  end

  assign sda_oe_o = sda_oe_q;

  AST_START_REARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> (state_q == ST_CTRL && bit_cnt_q == '0 && !sda_oe_q))
    else $error("start did not rearm decode"); // R1
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_w && !start_w) |=> (state_q == ST_IDLE && !sda_oe_q))
    else $error("stop did not release"); // R1
  AST_ACK_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_ack_q |-> (sda_oe_q && bit_cnt_q >= ACK_CLK))
    else $error("ack outside ninth clock"); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_q)
    else $error("idle slave drives SDA"); // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> (ptr_q == $past(ptr_q) + 1'b1))
    else $error("pointer did not step after write"); // R5
  AST_READ_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end && state_q == ST_READ && drv_ack_q) |=> (ptr_q == $past(ptr_q) + 1'b1))
    else $error("pointer did not step on read load"); // R8
endmodule

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
  localparam int unsigned MEM_AW = 8;
  localparam logic [2:0]  SEL    = 3'b101;
  localparam logic [3:0]  CODE   = 4'b1010;
  localparam int unsigned NVEC   = 6;
  // {pointer[15:0], data[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h0010_A5, 24'h7F21_3C, 24'hC03F_E1, 24'h1280_5A, 24'hABCD_0F, 24'h00FE_96
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2c_mem_slave #(.MEM_AW(MEM_AW)) u_i2c_mem_slave (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .sda_oe_o(sda_oe),
    .sel_i   (SEL)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wait_cyc(10);
    scl = 1'b1;   wait_cyc(10);
    sda_m = 1'b0; wait_cyc(10);
    scl = 1'b0;
  endtask

  task automatic bus_stop;
    wait_cyc(10); sda_m = 1'b0;
    wait_cyc(10); scl = 1'b1;
    wait_cyc(10); sda_m = 1'b1;
    wait_cyc(10);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    wait_cyc(10); sda_m = b;
    wait_cyc(10); scl = 1'b1;
    wait_cyc(10); s = sda_line;
    wait_cyc(10); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(~mack, s);
  endtask

  function automatic logic [7:0] ctrl(input logic rd);
    return {CODE, SEL, rd};
  endfunction

  // Start, write control byte, two pointer bytes; leaves the bus held.
  task automatic addr_phase(input logic [15:0] a, input string tag);
    logic ack;
    bus_start;
    send_byte(ctrl(1'b0), ack); chk({tag, " R2 ctrl ack"}, 16'(ack), 16'd1);
    send_byte(a[15:8], ack);    chk({tag, " R4 hi ack"}, 16'(ack), 16'd1);
    send_byte(a[7:0], ack);     chk({tag, " R4 lo ack"}, 16'(ack), 16'd1);
  endtask

  task automatic read_at(input logic [15:0] a, input logic [7:0] exp, input string tag);
    logic ack;
    logic [7:0] d;
    addr_phase(a, tag);
    bus_start;
    send_byte(ctrl(1'b1), ack); chk({tag, " R7 read ctrl ack"}, 16'(ack), 16'd1);
    recv_byte(1'b0, d);         chk({tag, " R7 data"}, 16'(d), 16'(exp));
    bus_stop;
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    wait_cyc(5);
    chk("R9 SDA released in reset", 16'(sda_oe), 16'd0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk("R9 SDA released after reset", 16'(sda_oe), 16'd0);

    // table walk: write one byte, read it back with a random read (R4 R5 R7)
    for (int v = 0; v < NVEC; v++) begin
      addr_phase(VEC[v][23:8], "vec");
      send_byte(VEC[v][7:0], ack); chk("R5 data ack", 16'(ack), 16'd1);
      bus_stop;
      read_at(VEC[v][23:8], VEC[v][7:0], "vec");
    end

    // sequential write and sequential read (R5 R6)
    addr_phase(16'h2040, "seq");
    for (int i = 0; i < 4; i++) begin
      send_byte(8'h31 + 8'(i), ack); chk("R5 seq data ack", 16'(ack), 16'd1);
    end
    bus_stop;
    addr_phase(16'h2040, "seq");
    bus_start;
    send_byte(ctrl(1'b1), ack); chk("R6 read ctrl ack", 16'(ack), 16'd1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, d); chk("R6 seq read data", 16'(d), 16'(8'h31 + 8'(i)));
    end
    wait_cyc(6);
    chk("R6 SDA released after master nack", 16'(sda_oe), 16'd0);
    bus_stop;

    // current-pointer read: pointer left at 0x2043 (R7)
    bus_start;
    send_byte(ctrl(1'b1), ack); chk("R7 current read ack", 16'(ack), 16'd1);
    recv_byte(1'b0, d);         chk("R7 current read data", 16'(d), 16'h34);
    bus_stop;

    // select mismatch: silent, nothing written (R3)
    bus_start;
    send_byte({CODE, SEL ^ 3'b001, 1'b0}, ack); chk("R3 wrong select no ack", 16'(ack), 16'd0);
    send_byte(8'h20, ack); chk("R3 later byte no ack", 16'(ack), 16'd0);
    send_byte(8'h40, ack); chk("R3 later byte no ack", 16'(ack), 16'd0);
    send_byte(8'hEE, ack); chk("R3 data no ack", 16'(ack), 16'd0);
    bus_stop;
    read_at(16'h2040, 8'h31, "R3 unchanged");

    // wrong type code (R2)
    bus_start;
    send_byte({4'b1011, SEL, 1'b0}, ack); chk("R2 wrong code no ack", 16'(ack), 16'd0);
    bus_stop;

    // stop mid transfer, then bytes without start are ignored (R1)
    bus_start;
    send_byte(ctrl(1'b0), ack); chk("R1 ctrl ack", 16'(ack), 16'd1);
    send_byte(8'h20, ack);
    bus_stop;
    send_byte(ctrl(1'b0), ack); chk("R1 no ack after stop", 16'(ack), 16'd0);
    chk("R1 SDA released after stop", 16'(sda_oe), 16'd0);
    bus_stop;

    // repeated start mid transfer keeps pointer (R1 R7)
    addr_phase(16'h2041, "rs");
    bus_start;
    send_byte(ctrl(1'b1), ack); chk("R1 repeated start ack", 16'(ack), 16'd1);
    recv_byte(1'b0, d);         chk("R7 pointer kept", 16'(d), 16'h32);
    bus_stop;

    // pointer wrap (R8)
    addr_phase(16'hFFFF, "wrap");
    send_byte(8'h11, ack); chk("R8 data ack", 16'(ack), 16'd1);
    send_byte(8'h22, ack); chk("R8 data ack", 16'(ack), 16'd1);
    bus_stop;
    read_at(16'h0000, 8'h22, "R8 wrap write");
    addr_phase(16'hFFFF, "wrap");
    bus_start;
    send_byte(ctrl(1'b1), ack);
    recv_byte(1'b1, d); chk("R8 read at top", 16'(d), 16'h11);
    recv_byte(1'b0, d); chk("R8 read after wrap", 16'(d), 16'h22);
    bus_stop;

    // aliasing on low pointer bits (R10)
    addr_phase(16'h1234, "alias");
    send_byte(8'h77, ack); chk("R10 data ack", 16'(ack), 16'd1);
    bus_stop;
    read_at(16'h0034, 8'h77, "R10 alias");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule